// File: doc/BRIEF.md
# Pipelined 4x4 Word Matrix Transposer

This block turns a 4x4 matrix of 32-bit words, presented as four 128-bit row vectors, into its transpose: four 128-bit vectors, each holding one column of the input. Word `c` of a row vector sits in bits `[32c+31:32c]`.

The unit contains no general crossbar. It uses only two kinds of pairwise interleave, one that merges the lower halves of two vectors and one that merges the upper halves.

The first rank applies four interleaves at word granularity, which swaps the words inside each 2x2 corner block. The second rank applies four interleaves at double-word granularity and finishes the transpose.

Each rank ends in one register stage. A new matrix can enter on every clock, and its transpose appears two clocks later with its own valid strobe. When no valid matrix enters, the registers keep their contents.

Top module: `mtx4_transpose`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `out_valid` is 0 and all four output vectors are 0.
- R2: `out_valid` equals the value `in_valid` had two clock edges earlier, including any gaps in the input stream.
- R3: Whenever `out_valid` is 1, word `r` of output vector `c` equals word `c` of input row `r` from two clocks earlier, where word `k` occupies bits `[32k+31:32k]` of a vector.
- R4: Matrices presented on consecutive clocks each come out transposed on consecutive clocks, at a throughput of one matrix per clock.
- R5: A clock edge with `in_valid` low loads nothing. Once the pipeline has drained, the output vectors keep the last transposed matrix whatever values the inputs then carry.
- R6: Asserting `rst_n` in the middle of a run clears `out_valid` and the output vectors at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Input rows carry a matrix this cycle |
| in_row0 | input | 128 | Input row 0 |
| in_row1 | input | 128 | Input row 1 |
| in_row2 | input | 128 | Input row 2 |
| in_row3 | input | 128 | Input row 3 |
| out_valid | output | 1 | Output vectors carry a transposed matrix |
| out_row0 | output | 128 | Column 0 of the input matrix |
| out_row1 | output | 128 | Column 1 of the input matrix |
| out_row2 | output | 128 | Column 2 of the input matrix |
| out_row3 | output | 128 | Column 3 of the input matrix |

## Verification
The assertions check four things on every cycle:
- the two-clock delay between `in_valid` and `out_valid`;
- the placement of all sixteen words of any valid output against the inputs two clocks earlier;
- the corner-block swap in the first rank's first vector;
- the rule that a rank with no valid input keeps its contents.

Only the bench scenarios can show three other behaviours: reset taking effect without a clock edge in the middle of a stream, outputs that keep the last matrix while the inputs change freely, and correct results for particular values such as all-ones words, uniform matrices and high-bit patterns sent back to back or with gaps.

// File: rtl/mtx4_pkg.sv
package mtx4_pkg;

  localparam int unsigned MAT_DIM = 4;

  typedef enum logic {
    MIX_LOW  = 1'b0,
    MIX_HIGH = 1'b1
  } mix_half_e;

endpackage

// File: rtl/mtx4_rst_sync.sv
module mtx4_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[DEPTH-1];

endmodule

// File: rtl/mtx4_interleave.sv
module mtx4_interleave
  import mtx4_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned GRAIN = 32,
  parameter mix_half_e   HALF  = MIX_LOW
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] mixed
);

  localparam int unsigned LANES = VEC_W / GRAIN;
  localparam int unsigned PAIRS = LANES / 2;
  localparam int unsigned FIRST = (HALF == MIX_HIGH) ? PAIRS : 0;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign mixed[(2*k)*GRAIN   +: GRAIN] = src_a[(FIRST+k)*GRAIN +: GRAIN];
    assign mixed[(2*k+1)*GRAIN +: GRAIN] = src_b[(FIRST+k)*GRAIN +: GRAIN];
  end

endmodule

// File: rtl/mtx4_stage.sv
module mtx4_stage
  import mtx4_pkg::*;
#(
  parameter int unsigned      VEC_W   = 128,
  parameter int unsigned      GRAIN   = 32,
  parameter logic [MAT_DIM-1:0] HI_SEL = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [MAT_DIM-1:0][VEC_W-1:0]   src_a,
  input  logic [MAT_DIM-1:0][VEC_W-1:0]   src_b,
  output logic                            out_valid,
  output logic [MAT_DIM-1:0][VEC_W-1:0]   dst
);

  logic [MAT_DIM-1:0][VEC_W-1:0] mix;
  logic [MAT_DIM-1:0][VEC_W-1:0] rows_d;
  logic [MAT_DIM-1:0][VEC_W-1:0] rows_q;
  logic                          load_en;
  logic                          valid_d;
  logic                          valid_q;

  for (genvar i = 0; i < MAT_DIM; i++) begin : g_op
    localparam mix_half_e SEL = HI_SEL[i] ? MIX_HIGH : MIX_LOW;
    mtx4_interleave #(
      .VEC_W (VEC_W),
      .GRAIN (GRAIN),
      .HALF  (SEL)
    ) u_mix (
      .src_a (src_a[i]),
      .src_b (src_b[i]),
      .mixed (mix[i])
    );
  end

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    rows_d  = load_en ? mix : rows_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rows_q  <= rows_d;
      valid_q <= valid_d;
    end
  end

  assign dst       = rows_q;
  assign out_valid = valid_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rows_q)); // R5

endmodule

// File: rtl/mtx4_transpose.sv
module mtx4_transpose
  import mtx4_pkg::*;
#(
  parameter int unsigned ELEM_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ELEM_W*MAT_DIM-1:0] in_row0,
  input  logic [ELEM_W*MAT_DIM-1:0] in_row1,
  input  logic [ELEM_W*MAT_DIM-1:0] in_row2,
  input  logic [ELEM_W*MAT_DIM-1:0] in_row3,
  output logic                      out_valid,
  output logic [ELEM_W*MAT_DIM-1:0] out_row0,
  output logic [ELEM_W*MAT_DIM-1:0] out_row1,
  output logic [ELEM_W*MAT_DIM-1:0] out_row2,
  output logic [ELEM_W*MAT_DIM-1:0] out_row3
);

  localparam int unsigned ROW_W = ELEM_W * MAT_DIM;

  logic                          rst_sync_n;
  logic [MAT_DIM-1:0][ROW_W-1:0] in_m;
  logic [MAT_DIM-1:0][ROW_W-1:0] a1;
  logic [MAT_DIM-1:0][ROW_W-1:0] b1;
  logic [MAT_DIM-1:0][ROW_W-1:0] mid;
  logic                          mid_valid;
  logic [MAT_DIM-1:0][ROW_W-1:0] a2;
  logic [MAT_DIM-1:0][ROW_W-1:0] b2;
  logic [MAT_DIM-1:0][ROW_W-1:0] res;
  logic                          res_valid;

  mtx4_rst_sync #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_m = {in_row3, in_row2, in_row1, in_row0};

  // rank one: word grain, pairs (0,1) and (2,3), low then high
  assign a1 = {in_m[2], in_m[0], in_m[2], in_m[0]};
  assign b1 = {in_m[3], in_m[1], in_m[3], in_m[1]};

  mtx4_stage #(
    .VEC_W  (ROW_W),
    .GRAIN  (ELEM_W),
    .HI_SEL (4'b1100)
  ) u_rank1 (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .src_a     (a1),
    .src_b     (b1),
    .out_valid (mid_valid),
    .dst       (mid)
  );

  // rank two: double-word grain, pairs (T0,T1) and (T2,T3)
  assign a2 = {mid[2], mid[2], mid[0], mid[0]};
  assign b2 = {mid[3], mid[3], mid[1], mid[1]};

  mtx4_stage #(
    .VEC_W  (ROW_W),
    .GRAIN  (2*ELEM_W),
    .HI_SEL (4'b1010)
  ) u_rank2 (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (mid_valid),
    .src_a     (a2),
    .src_b     (b2),
    .out_valid (res_valid),
    .dst       (res)
  );

  assign out_valid = res_valid;
  assign out_row0  = res[0];
  assign out_row1  = res[1];
  assign out_row2  = res[2];
  assign out_row3  = res[3];

  // cycles since reset release, saturating, used only to guard $past
  logic [1:0] age_q;
  logic [1:0] age_d;

  always_comb begin
    age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      age_q <= '0;
    end else begin
      age_q <= age_d;
    end
  end

  AST_FRESH_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd0) |-> (!out_valid && res == '0)); // R1

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

  AST_CORNER_SWAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q != 2'd0 && mid_valid) |->
      (mid[0] == {$past(in_m[1][ELEM_W +: ELEM_W]), $past(in_m[0][ELEM_W +: ELEM_W]),
                  $past(in_m[1][0 +: ELEM_W]),      $past(in_m[0][0 +: ELEM_W])})); // R3

  for (genvar r = 0; r < MAT_DIM; r++) begin : g_chk_r
    for (genvar c = 0; c < MAT_DIM; c++) begin : g_chk_c
      AST_WORD_PLACE: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (age_q == 2'd2 && out_valid) |->
          (res[c][r*ELEM_W +: ELEM_W] == $past(in_m[r][c*ELEM_W +: ELEM_W], 2))); // R3
    end
  end

endmodule

// File: tb/mtx4_transpose_bench.sv
module mtx4_transpose_bench;

  localparam int E  = 32;
  localparam int RW = 4 * E;
  localparam int NV = 6;

  typedef logic [3:0][RW-1:0] mat_t;

  // {base, multiplier}: word(r,c) = base ^ (mult * (4r+c+1))
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'hA5A5_0000, 32'h0101_0101},
    {32'h1234_5678, 32'h0000_0000},
    {32'h0000_0000, 32'h1000_0000},
    {32'h8000_0001, 32'h00F0_0F01}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic [RW-1:0] in_row0, in_row1, in_row2, in_row3;
  logic          out_valid;
  logic [RW-1:0] out_row0, out_row1, out_row2, out_row3;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  mtx4_transpose #(.ELEM_W(E)) u_mtx4_transpose (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_row0   (in_row0),
    .in_row1   (in_row1),
    .in_row2   (in_row2),
    .in_row3   (in_row3),
    .out_valid (out_valid),
    .out_row0  (out_row0),
    .out_row1  (out_row1),
    .out_row2  (out_row2),
    .out_row3  (out_row3)
  );

  function automatic mat_t build(logic [31:0] base, logic [31:0] mult);
    mat_t m;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        m[r][c*E +: E] = base ^ (mult * 32'(r*4 + c + 1));
    return m;
  endfunction

  function automatic mat_t flip(mat_t m);
    mat_t t;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        t[c][r*E +: E] = m[r][c*E +: E];
    return t;
  endfunction

  function automatic mat_t grab();
    return {out_row3, out_row2, out_row1, out_row0};
  endfunction

  task automatic drive(mat_t m, logic v);
    in_row0  = m[0];
    in_row1  = m[1];
    in_row2  = m[2];
    in_row3  = m[3];
    in_valid = v;
  endtask

  task automatic chk(bit ok, string req, logic [512:0] act, logic [512:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  mat_t src [NV];
  mat_t last;

  initial begin
    for (int i = 0; i < NV; i++) src[i] = build(VEC[i][63:32], VEC[i][31:0]);
    rst_n = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(!out_valid && grab() == '0, "R1 in reset",
        {out_valid, grab()}, 513'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && grab() == '0, "R1 after release",
        {out_valid, grab()}, 513'd0);

    // table walk: back-to-back matrices (R3, R4)
    for (int t = 0; t < NV + 2; t++) begin
      if (t >= 2)
        chk(out_valid && grab() == flip(src[t-2]), "R3 R4 stream",
            {out_valid, grab()}, {1'b1, flip(src[t-2])});
      if (t < NV) drive(src[t], 1'b1);
      else        drive('0, 1'b0);
      @(negedge clk);
    end

    // R5: inputs change with valid low, outputs keep last matrix
    last = flip(src[NV-1]);
    for (int t = 0; t < 4; t++) begin
      chk(!out_valid && grab() == last, "R5 hold",
          {out_valid, grab()}, {1'b0, last});
      drive(src[t], 1'b0);
      @(negedge clk);
    end

    // R2: gaps in the valid stream keep their position
    begin
      logic [6:0] pat;
      pat = 7'b0011101;
      for (int t = 0; t < 7; t++) begin
        if (t >= 2) begin
          chk(out_valid == pat[t-2], "R2 valid delay",
              {512'd0, out_valid}, {512'd0, pat[t-2]});
          if (pat[t-2])
            chk(grab() == flip(src[t-2]), "R2 R3 gapped data",
                {1'b0, grab()}, {1'b0, flip(src[t-2])});
        end
        drive(src[t % NV], pat[t]);
        @(negedge clk);
      end
    end

    // R6: asynchronous clear mid-stream
    drive(src[2], 1'b1);
    repeat (2) @(negedge clk);
    chk(out_valid, "R6 precondition", {512'd0, out_valid}, 513'd1);
    #5;
    rst_n = 1'b0;
    #1;
    chk(!out_valid && grab() == '0, "R6 async clear",
        {out_valid, grab()}, 513'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    chk(!out_valid && grab() == '0, "R1 R6 after reclear",
        {out_valid, grab()}, 513'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule